// File: doc/BRIEF.md
# Two-Level Instruction Address Translation Buffer

This block translates instruction-fetch virtual addresses into physical addresses through two fully associative levels. A very small first level answers most fetches and returns the translation one cycle after the request is accepted. When the first level misses, the block raises its stall output and searches a larger second level. It then writes the found mapping into the first level and returns the translation over a fixed three-cycle refill path. The first level replaces entries in FIFO order. The second level picks a free slot if one exists, and otherwise takes a pseudo-random victim from a free-running LFSR.

When both levels miss, the block raises a miss output and holds the stall. An external page walker then supplies the mapping through the fill port, and the pending lookup completes over the normal refill path. The walker may also use the fill port at any other time to preload second-level entries. A single-cycle invalidate input empties both levels and drops any lookup still in flight. Pages are 4 KB: the low 12 address bits bypass translation and the upper bits form the tag.

Top module: `itlb_two_level`

## Requirements
- R1: After reset, stall, miss and rsp_valid are low and both levels are empty, so the first lookup misses in both levels.
- R2: A request accepted while stall is low that hits the first level gives rsp_valid and rsp_hit high in the next cycle. No stall is raised.
- R3: A first-level miss that hits the second level holds stall high for the three cycles after the acceptance edge. In the fourth cycle, rsp_valid is high, rsp_hit is low and stall is low. The page is then held in the first level.
- R4: rsp_paddr is the 20-bit physical page number of the matching entry followed by bits 11:0 of the request address, copied unchanged.
- R5: The first level (2 entries) refills a free slot first. Once it is full, it evicts the oldest refill even if that entry was used more recently.
- R6: When both levels miss, miss rises in the second cycle after acceptance and stays high together with stall until fill_valid. From the fill edge, miss is low and the response follows three cycles later.
- R7: req_valid has no effect while stall is high. Only the pending lookup responds, and the ignored page is not loaded into either level.
- R8: A second-level fill goes to a free slot while one exists, so 64 distinct fills all remain present.
- R9: A fill into a full second level replaces exactly one existing entry. The new page can be looked up afterwards.
- R10: inval_all empties both levels in one cycle. It also aborts a lookup in flight: in the next cycle stall, miss and rsp_valid are low, and no response follows.
- R11: A fill while the block is idle changes no output. It makes that page a second-level hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request, taken when stall is low |
| req_vaddr | input | 32 | Virtual fetch address |
| rsp_valid | output | 1 | Translation valid this cycle |
| rsp_hit | output | 1 | Response came straight from the first level |
| rsp_paddr | output | 32 | Translated physical address |
| stall | output | 1 | Lookup in progress, requester must wait |
| miss | output | 1 | Both levels missed; waiting for a fill |
| fill_valid | input | 1 | Write a second-level entry |
| fill_vpn | input | 20 | Virtual page number to write |
| fill_ppn | input | 20 | Physical page number to write |
| inval_all | input | 1 | Clear both levels and abort a pending lookup |

## Verification
The bound assertions check the handshake rules on every cycle. They confirm that miss implies stall and that a response never appears while stall is high. They also check that an accepted first-level hit answers in the next cycle with its offset intact, that a stall never lasts a single cycle and ends in a response unless it was aborted, and that invalidation clears the outputs. Other behaviour depends on what the levels hold, so only the bench scenarios can show it: FIFO rather than LRU eviction, free-slot-first placement, random replacement removing exactly one old page, requests ignored during a stall, and the emptying of both levels. The bench compares these against its behavioural model on every cycle of each transaction.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L2,
    ST_WAIT,
    ST_LOAD,
    ST_RESP
  } itlb_state_e;

  // Galois feedback masks for maximal-length sequences
  function automatic logic [31:0] lfsr_taps(input int width);
    case (width)
      8:       return 32'h0000_00B8;
      16:      return 32'h0000_B400;
      24:      return 32'h00E1_0000;
      32:      return 32'h8020_0003;
      default: return 32'h0000_B400;
    endcase
  endfunction

endpackage

// File: rtl/itlb_lfsr.sv
module itlb_lfsr #(
  parameter int W    = 16,
  parameter int SEED = 1
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] value
);
  import itlb_pkg::*;

  localparam logic [31:0] TAPS32 = lfsr_taps(W);
  localparam logic [W-1:0] TAPS  = TAPS32[W-1:0];

  logic [W-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= W'(SEED);
    end else begin
      state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
    end
  end

  assign value = state_q;

endmodule

// File: rtl/itlb_micro.sv
module itlb_micro #(
  parameter int ENT   = 2,
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int IDX_W = (ENT > 1) ? $clog2(ENT) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENT - 1);

  logic [ENT-1:0]   val_q;
  logic [VPN_W-1:0] tag_q [ENT];
  logic [PPN_W-1:0] ppn_q [ENT];
  logic [IDX_W-1:0] ptr_q;
  logic [ENT-1:0]   match;
  logic [IDX_W-1:0] slot;
  logic             free_found;

  for (genvar g = 0; g < ENT; g++) begin : g_cmp
    assign match[g] = val_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENT; i++) begin
      if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
    lk_hit = |match;
  end

  // free slot first, otherwise the FIFO pointer
  always_comb begin
    slot       = ptr_q;
    free_found = 1'b0;
    for (int i = 0; i < ENT; i++) begin
      if (!free_found && !val_q[i]) begin
        slot       = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val_q <= '0;
      ptr_q <= '0;
    end else if (wr_en) begin
      val_q[slot] <= 1'b1;
      ptr_q       <= (slot == LAST) ? '0 : slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst && !clr) begin
      tag_q[slot] <= wr_vpn;
      ppn_q[slot] <= wr_ppn;
    end
  end

endmodule

// File: rtl/itlb_l2.sv
module itlb_l2 #(
  parameter int ENT    = 64,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int LFSR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn
);
  localparam int IDX_W = (ENT > 1) ? $clog2(ENT) : 1;

  logic [ENT-1:0]    val_q;
  logic [VPN_W-1:0]  tag_q [ENT];
  logic [PPN_W-1:0]  ppn_q [ENT];
  logic [ENT-1:0]    match;
  logic [LFSR_W-1:0] rnd;
  logic [IDX_W-1:0]  victim;
  logic [IDX_W-1:0]  slot;
  logic              free_found;

  itlb_lfsr #(.W(LFSR_W), .SEED(1)) u_lfsr (
    .clk   (clk),
    .rst   (rst),
    .value (rnd)
  );

  assign victim = IDX_W'(rnd % LFSR_W'(ENT));

  for (genvar g = 0; g < ENT; g++) begin : g_cmp
    assign match[g] = val_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < ENT; i++) begin
      if (match[i]) lk_ppn = lk_ppn | ppn_q[i];
    end
    lk_hit = |match;
  end

  always_comb begin
    slot       = victim;
    free_found = 1'b0;
    for (int i = 0; i < ENT; i++) begin
      if (!free_found && !val_q[i]) begin
        slot       = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      val_q <= '0;
    end else if (wr_en) begin
      val_q[slot] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !rst && !clr) begin
      tag_q[slot] <= wr_vpn;
      ppn_q[slot] <= wr_ppn;
    end
  end

endmodule

// File: rtl/itlb_two_level.sv
module itlb_two_level #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int U_ENT  = 2,
  parameter int L2_ENT = 64,
  parameter int LFSR_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  input  logic [VA_W-1:0]       req_vaddr,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [PA_W-1:0]       rsp_paddr,
  output logic                  stall,
  output logic                  miss,
  input  logic                  fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic                  inval_all
);
  import itlb_pkg::*;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;

  itlb_state_e      state_q;
  logic [VPN_W-1:0] pend_vpn_q;
  logic [OFF_W-1:0] pend_off_q;
  logic [PPN_W-1:0] pend_ppn_q;
  logic             stall_q, miss_q;
  logic             rsp_valid_q, rsp_hit_q;
  logic [PA_W-1:0]  rsp_paddr_q;

  logic             u_hit;
  logic [PPN_W-1:0] u_ppn;
  logic             l2_hit;
  logic [PPN_W-1:0] l2_ppn;
  logic             u_wr;
  logic             l2_wr;
  logic             accept;

  assign accept = req_valid && (state_q == ST_IDLE) && !inval_all;
  assign u_wr   = (state_q == ST_LOAD) && !inval_all;
  assign l2_wr  = fill_valid && !inval_all;

  itlb_micro #(.ENT(U_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_micro (
    .clk    (clk),
    .rst    (rst),
    .clr    (inval_all),
    .lk_vpn (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit (u_hit),
    .lk_ppn (u_ppn),
    .wr_en  (u_wr),
    .wr_vpn (pend_vpn_q),
    .wr_ppn (pend_ppn_q)
  );

  itlb_l2 #(.ENT(L2_ENT), .VPN_W(VPN_W), .PPN_W(PPN_W), .LFSR_W(LFSR_W)) u_l2 (
    .clk    (clk),
    .rst    (rst),
    .clr    (inval_all),
    .lk_vpn (pend_vpn_q),
    .lk_hit (l2_hit),
    .lk_ppn (l2_ppn),
    .wr_en  (l2_wr),
    .wr_vpn (fill_vpn),
    .wr_ppn (fill_ppn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      stall_q     <= 1'b0;
      miss_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_paddr_q <= '0;
      pend_vpn_q  <= '0;
      pend_off_q  <= '0;
      pend_ppn_q  <= '0;
    end else if (inval_all) begin
      state_q     <= ST_IDLE;
      stall_q     <= 1'b0;
      miss_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (u_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_hit_q   <= 1'b1;
              rsp_paddr_q <= {u_ppn, req_vaddr[OFF_W-1:0]};
            end else begin
              state_q    <= ST_L2;
              stall_q    <= 1'b1;
              pend_vpn_q <= req_vaddr[VA_W-1:OFF_W];
              pend_off_q <= req_vaddr[OFF_W-1:0];
            end
          end
        end
        ST_L2: begin
          if (l2_hit) begin
            pend_ppn_q <= l2_ppn;
            state_q    <= ST_LOAD;
          end else begin
            miss_q  <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (fill_valid) begin
            miss_q  <= 1'b0;
            state_q <= ST_L2;
          end
        end
        ST_LOAD: begin
          state_q <= ST_RESP;
        end
        ST_RESP: begin
          rsp_valid_q <= 1'b1;
          rsp_hit_q   <= 1'b0;
          rsp_paddr_q <= {pend_ppn_q, pend_off_q};
          stall_q     <= 1'b0;
          state_q     <= ST_IDLE;
        end
        default: begin
          state_q <= ST_IDLE;
          stall_q <= 1'b0;
          miss_q  <= 1'b0;
        end
      endcase
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_paddr = rsp_paddr_q;
  assign stall     = stall_q;
  assign miss      = miss_q;

endmodule

// File: rtl/itlb_two_level_chk.sv
module itlb_two_level_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic            inval_all,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            stall,
  input logic            miss,
  input logic            u_hit
);

  // R6
  miss_holds_stall_chk: assert property (@(posedge clk) disable iff (rst)
    miss |-> stall);

  // R3
  no_rsp_in_stall_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !stall);

  // R2
  micro_hit_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !stall && !inval_all && u_hit) |=> (rsp_valid && rsp_hit));

  // R4
  offset_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_hit) |-> (rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R3
  stall_multi_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |=> stall);

  // R3
  stall_ends_in_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(stall) && !$past(inval_all)) |-> (rsp_valid && !rsp_hit));

  // R10
  inval_clears_chk: assert property (@(posedge clk) disable iff (rst)
    inval_all |=> (!stall && !miss && !rsp_valid));

endmodule

bind itlb_two_level itlb_two_level_chk #(
  .VA_W  (VA_W),
  .PA_W  (PA_W),
  .OFF_W (OFF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_vaddr (req_vaddr),
  .inval_all (inval_all),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_paddr (rsp_paddr),
  .stall     (stall),
  .miss      (miss),
  .u_hit     (u_hit)
);

// File: tb/itlb_two_level_bench.sv
module itlb_two_level_bench;
  localparam int VPN_W  = 20;
  localparam int PPN_W  = 20;
  localparam int U_ENT  = 2;
  localparam int L2_ENT = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [31:0]      req_vaddr = '0;
  logic             rsp_valid, rsp_hit, stall, miss;
  logic [31:0]      rsp_paddr;
  logic             fill_valid = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             inval_all = 1'b0;

  int tests = 0;
  int fails = 0;

  // behavioural model state
  logic [VPN_W-1:0] m_l2[$];
  logic [VPN_W-1:0] m_uvpn[U_ENT];
  bit               m_uval[U_ENT];
  int               m_uptr = 0;

  always #10 clk = ~clk;

  itlb_two_level u_itlb_two_level (
    .clk (clk), .rst (rst),
    .req_valid (req_valid), .req_vaddr (req_vaddr),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_paddr (rsp_paddr),
    .stall (stall), .miss (miss),
    .fill_valid (fill_valid), .fill_vpn (fill_vpn), .fill_ppn (fill_ppn),
    .inval_all (inval_all)
  );

  function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
    return PPN_W'(v ^ 20'h5A5A5);
  endfunction

  function automatic bit l2_has(input logic [VPN_W-1:0] v);
    foreach (m_l2[i]) if (m_l2[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit u_has(input logic [VPN_W-1:0] v);
    for (int i = 0; i < U_ENT; i++) if (m_uval[i] && m_uvpn[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void u_refill(input logic [VPN_W-1:0] v);
    int slot = -1;
    for (int i = 0; i < U_ENT; i++) if (slot < 0 && !m_uval[i]) slot = i;
    if (slot < 0) slot = m_uptr;
    m_uval[slot] = 1'b1;
    m_uvpn[slot] = v;
    m_uptr = (slot + 1) % U_ENT;
  endfunction

  function automatic void model_clear();
    m_l2.delete();
    for (int i = 0; i < U_ENT; i++) m_uval[i] = 1'b0;
    m_uptr = 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input string what,
                        input longint act, input longint exp);
    chk(act == exp, tag, what, act, exp);
  endtask

  task automatic idle_check(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk_eq(tag, "idle stall", stall, 0);
      chk_eq(tag, "idle miss", miss, 0);
      chk_eq(tag, "idle rsp_valid", rsp_valid, 0);
    end
  endtask

  task automatic fill_l2(input logic [VPN_W-1:0] v);
    fill_valid = 1'b1; fill_vpn = v; fill_ppn = ppn_of(v);
    @(negedge clk);
    fill_valid = 1'b0;
    m_l2.push_back(v);
    // R11: idle fill leaves outputs untouched
    chk_eq("R11", "fill stall", stall, 0);
    chk_eq("R11", "fill rsp_valid", rsp_valid, 0);
    chk_eq("R11", "fill miss", miss, 0);
  endtask

  // drive one lookup and compare every cycle with the model; caller is at a negedge
  task automatic lookup(input logic [31:0] va, input string ctx,
                        input bit hold_other = 1'b0, input logic [31:0] other = '0);
    logic [VPN_W-1:0] v = va[31:12];
    logic [31:0] exp_pa = {ppn_of(v), va[11:0]};
    bit uh = u_has(v);
    bit lh = l2_has(v);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    if (uh) begin
      chk_eq("R2", {ctx, " rsp_valid"}, rsp_valid, 1);
      chk_eq("R2", {ctx, " rsp_hit"}, rsp_hit, 1);
      chk_eq("R2", {ctx, " stall"}, stall, 0);
      chk_eq("R4", {ctx, " paddr"}, rsp_paddr, exp_pa);
    end else begin
      chk_eq("R3", {ctx, " stall c0"}, stall, 1);
      chk_eq("R3", {ctx, " rsp_valid c0"}, rsp_valid, 0);
      if (hold_other) begin req_valid = 1'b1; req_vaddr = other; end
      @(negedge clk);
      if (!lh) begin
        req_valid = 1'b0;
        chk_eq("R6", {ctx, " miss raised"}, miss, 1);
        chk_eq("R6", {ctx, " stall held"}, stall, 1);
        for (int i = 0; i < 4; i++) begin
          @(negedge clk);
          chk_eq("R6", {ctx, " miss wait"}, miss, 1);
          chk_eq("R6", {ctx, " rsp wait"}, rsp_valid, 0);
        end
        fill_valid = 1'b1; fill_vpn = v; fill_ppn = ppn_of(v);
        @(negedge clk);
        fill_valid = 1'b0;
        m_l2.push_back(v);
        chk_eq("R6", {ctx, " miss cleared"}, miss, 0);
        chk_eq("R6", {ctx, " stall f0"}, stall, 1);
        @(negedge clk);
        chk_eq("R6", {ctx, " stall f1"}, stall, 1);
        @(negedge clk);
        chk_eq("R6", {ctx, " stall f2"}, stall, 1);
      end else begin
        chk_eq("R3", {ctx, " stall c1"}, stall, 1);
        chk_eq("R3", {ctx, " miss c1"}, miss, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk_eq("R3", {ctx, " stall c2"}, stall, 1);
        chk_eq(hold_other ? "R7" : "R3", {ctx, " rsp c2"}, rsp_valid, 0);
      end
      @(negedge clk);
      chk_eq("R3", {ctx, " rsp_valid"}, rsp_valid, 1);
      chk_eq("R3", {ctx, " rsp_hit"}, rsp_hit, 0);
      chk_eq("R3", {ctx, " stall end"}, stall, 0);
      chk_eq("R4", {ctx, " paddr"}, rsp_paddr, exp_pa);
      u_refill(v);
    end
    @(negedge clk);
    chk_eq(hold_other ? "R7" : "R3", {ctx, " single rsp"}, rsp_valid, 0);
  endtask

  // probe a page that may have been evicted; returns 1 when the miss was seen
  task automatic probe(input logic [31:0] va, output bit missed);
    logic [VPN_W-1:0] v = va[31:12];
    missed = 1'b0;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk_eq("R9", "probe stall c0", stall, 1);
    @(negedge clk);
    if (miss) begin
      missed = 1'b1;
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      model_clear();
      chk_eq("R10", "abort stall", stall, 0);
      chk_eq("R10", "abort miss", miss, 0);
      chk_eq("R10", "abort rsp", rsp_valid, 0);
      idle_check("R10", 4);
    end else begin
      @(negedge clk);
      @(negedge clk);
      chk_eq("R9", "probe rsp", rsp_valid, 1);
      chk_eq("R9", "probe paddr", rsp_paddr, {ppn_of(v), va[11:0]});
      u_refill(v);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    bit missed;
    bit found;
    model_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk_eq("R1", "reset stall", stall, 0);
    chk_eq("R1", "reset miss", miss, 0);
    chk_eq("R1", "reset rsp_valid", rsp_valid, 0);
    idle_check("R1", 2);
    lookup(32'h0001_2345, "R1 first lookup");
    lookup(32'h0001_2FFF, "R2 same page");
    lookup(32'h0001_2000, "R2 zero offset");
    fill_l2(20'h00034);
    idle_check("R11", 2);
    lookup(32'h0003_4ABC, "R11 preloaded");
    lookup(32'h0003_4001, "R4 offset");
    // R7: hold a second request through the stall
    fill_l2(20'h00056);
    lookup(32'h0005_6777, "R7 stalled", 1'b1, 32'h0007_8111);
    lookup(32'h0007_8111, "R7 ignored page");
    // R10: single-cycle clear of both levels
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    model_clear();
    chk_eq("R10", "inval stall", stall, 0);
    chk_eq("R10", "inval rsp", rsp_valid, 0);
    lookup(32'h0001_2345, "R10 after clear");
    // R5: FIFO order from a cleared state
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    model_clear();
    lookup(32'h000E_0010, "R5 fill E");
    lookup(32'h000F_0020, "R5 fill F");
    lookup(32'h000E_0030, "R5 reuse E");
    lookup(32'h000A_0040, "R5 fill G");
    lookup(32'h000F_0050, "R5 F kept");
    lookup(32'h000E_0060, "R5 E evicted");
    // R8: 64 fills all present
    inval_all = 1'b1;
    @(negedge clk);
    inval_all = 1'b0;
    model_clear();
    for (int i = 0; i < L2_ENT; i++) fill_l2(VPN_W'(20'h40000 + i));
    for (int i = 0; i < L2_ENT; i++)
      lookup({VPN_W'(20'h40000 + i), 12'(i * 37)}, "R8 all present");
    // R9: two more pages into the full level
    lookup(32'h0009_9123, "R9 new page P");
    lookup(32'h0009_A456, "R9 new page Q");
    lookup(32'h0009_9789, "R9 P from micro");
    found = 1'b0;
    for (int i = 0; i < L2_ENT && !found; i++) begin
      probe({VPN_W'(20'h40000 + i), 12'h0AA}, missed);
      if (missed) found = 1'b1;
    end
    chk_eq("R9", "old page replaced", found, 1);
    lookup(32'h0004_0010, "R10 empty after abort");
    idle_check("R3", 3);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule